// File: doc/BRIEF.md
# DMA Bus-Mode Transfer Sequencer

This block decides when a single DMA channel holds a shared bus that it shares with a CPU, and how long it keeps it. It watches a level-sensitive, active-low transfer request and a software enable. Once both are seen, it raises a bus request. It waits for a grant, then issues one strobe per data beat until its policy says the bus must go back. Addresses, data and multi-channel arbitration are handled elsewhere. Here the bus is a plain request/grant pair.

Three holding policies are available. Cycle-steal mode hands the bus back after every beat. Burst mode keeps the bus until the whole transfer count is used up. Block mode keeps the bus for one block of beats and then hands it back. A yield setting turns a burst into per-beat release, and block mode ignores that setting. The transfer ends in one of two ways. When the count runs out, a done pulse is raised. When one of three fault inputs fires, an error pulse is raised. Both endings raise a request to clear the enable. Dropping the enable stops the sequence, but a beat that was already requested still completes.

Top module: `dma_seq_top`

## Requirements
- R1: `bus_req` rises only in the cycle after `enable` was high and `req_n` was low (request active at logic 0); it stays low while either condition is missing.
- R2: With `mode` = 00 (cycle steal), every ownership carries exactly one beat, and `bus_req` is low for at least one cycle between beats.
- R3: With `mode` = 01 (burst) and `yield_en` low, all beats run back to back in one ownership, and the bus is released in the cycle of the last beat.
- R4: A burst that has started continues to the end of the count even if `req_n` returns high.
- R5: With `mode` = 01 and `yield_en` high, the bus is released after every beat, as in cycle-steal mode.
- R6: With `mode[1]` = 1 (block), beats come in groups of `blk_len` inside one ownership, with a release between groups; `mode[0]` and `yield_en` are ignored.
- R7: Each beat uses up one unit of the count loaded from `total_cnt`. The number of beats equals that count. The last beat raises `irq_done` and `en_clr` for exactly one cycle, and releases the bus in that same cycle.
- R8: In cycle-steal or burst mode, if `enable` drops after `bus_req` rose, the pending beat still completes once granted; no further request follows and no done is raised.
- R9: A pulse on `err_size`, `err_rpt_end` or `err_ovf` during an active transfer stops further beats, drops the bus, and raises `irq_err` and `en_clr` for one cycle.
- R10: `total_cnt` and `blk_len` are captured while the block is idle with `enable` low; a captured count of zero never raises `bus_req`.
- R11: `beat` is raised only in the cycle after one in which both `bus_req` and `bus_gnt` were high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Software enable for the channel |
| req_n | input | 1 | Transfer request, active-low level |
| mode | input | 2 | 00 cycle steal, 01 burst, 1x block |
| yield_en | input | 1 | Release the bus between burst beats |
| total_cnt | input | CNT_W | Number of beats to transfer |
| blk_len | input | CNT_W | Beats per block in block mode |
| err_size | input | 1 | Transfer size fault pulse |
| err_rpt_end | input | 1 | Repeat-size end pulse |
| err_ovf | input | 1 | Extended repeat overflow pulse |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Bus request, held while owning |
| beat | output | 1 | One-cycle strobe per completed transfer |
| irq_done | output | 1 | One-cycle pulse on count exhaustion |
| irq_err | output | 1 | One-cycle pulse on a fault abort |
| en_clr | output | 1 | One-cycle request to clear the enable |

## Verification
The assertions assume that the arbiter only grants while `bus_req` is high and keeps the grant until the request drops. The stimulus follows this: the grant is generated from `bus_req` with a random latency and is held. The assertions also assume that `mode` does not change while a transfer is running. In block mode they assume that the total count is a whole multiple of `blk_len`. The random cases therefore set mode, counts and yield only while `enable` is low, and they build each block-mode total as a whole number of blocks. Fault pulses are sent only while a burst is running, one per run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam logic [1:0] MODE_CS    = 2'b00;
  localparam logic [1:0] MODE_BURST = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] total_in,
  input  logic [CNT_W-1:0] blk_in,
  output logic             cnt_zero,
  output logic             last_total,
  output logic             last_blk
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] blk_left_q;
  logic [CNT_W-1:0] blk_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q   <= '0;
      blk_left_q <= '0;
      blk_len_q  <= '0;
    end else if (load) begin
      remain_q   <= total_in;
      blk_left_q <= blk_in;
      blk_len_q  <= blk_in;
    end else if (step) begin
      remain_q   <= remain_q - ONE;
      blk_left_q <= (blk_left_q <= ONE) ? blk_len_q : blk_left_q - ONE;
    end
  end

  assign cnt_zero   = (remain_q == '0);
  assign last_total = (remain_q == ONE);
  assign last_blk   = (blk_left_q <= ONE);

  // R7: a beat is never taken from an exhausted count
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    step |-> !cnt_zero);
  // R10: a load always leaves the counter at the requested value
  p_load_value_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> (remain_q == $past(total_in)));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       req_n,
  input  logic [1:0] mode,
  input  logic       yield_en,
  input  logic       fault,
  input  logic       bus_gnt,
  input  logic       cnt_zero,
  input  logic       last_total,
  input  logic       last_blk,
  output logic       load,
  output logic       step,
  output logic       bus_req,
  output logic       beat,
  output logic       irq_done,
  output logic       irq_err,
  output logic       en_clr
);
  seq_st_e st_q;
  logic    halted_q;
  logic    fault_hit;
  logic    start;
  logic    hold;

  always_comb begin
    fault_hit = fault && ((st_q != ST_IDLE) || (enable && !halted_q));
    step      = (st_q == ST_OWN) && bus_gnt && !fault_hit;
    load      = (st_q == ST_IDLE) && !enable;
    start     = (st_q == ST_IDLE) && enable && !halted_q && !req_n
                && !cnt_zero && !fault_hit;
    if (mode[1]) hold = !last_blk;
    else         hold = (mode == MODE_BURST) && !yield_en && enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      halted_q <= 1'b0;
      bus_req  <= 1'b0;
      beat     <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      en_clr   <= 1'b0;
    end else begin
      beat     <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      en_clr   <= 1'b0;
      if (!enable) halted_q <= 1'b0;
      if (fault_hit) begin
        st_q     <= ST_IDLE;
        bus_req  <= 1'b0;
        irq_err  <= 1'b1;
        en_clr   <= 1'b1;
        halted_q <= 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: if (start) begin
            st_q    <= ST_REQ;
            bus_req <= 1'b1;
          end
          ST_REQ: if (bus_gnt) st_q <= ST_OWN;
          ST_OWN: if (step) begin
            beat <= 1'b1;
            if (last_total) begin
              st_q     <= ST_IDLE;
              bus_req  <= 1'b0;
              irq_done <= 1'b1;
              en_clr   <= 1'b1;
              halted_q <= 1'b1;
            end else if (!hold) begin
              st_q    <= ST_IDLE;
              bus_req <= 1'b0;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: a new request follows an enabled, active request line
  p_req_gated_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(enable) && !$past(req_n)));
  // R2: in cycle steal the bus is dropped with every beat
  p_cs_release_r2: assert property (@(posedge clk) disable iff (rst)
    (beat && $past(mode) == MODE_CS) |-> !bus_req);
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);
  // R9: an enable-clear request always carries a cause
  p_clr_cause_r9: assert property (@(posedge clk) disable iff (rst)
    en_clr |-> (irq_done || irq_err));
  // R9: no beat is reported together with a fault abort
  p_err_no_beat_r9: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> !beat);
  // R11: beats only follow a granted, requested cycle
  p_beat_granted_r11: assert property (@(posedge clk) disable iff (rst)
    beat |-> $past(bus_req && bus_gnt));
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             req_n,
  input  logic [1:0]       mode,
  input  logic             yield_en,
  input  logic [CNT_W-1:0] total_cnt,
  input  logic [CNT_W-1:0] blk_len,
  input  logic             err_size,
  input  logic             err_rpt_end,
  input  logic             err_ovf,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             beat,
  output logic             irq_done,
  output logic             irq_err,
  output logic             en_clr
);
  logic fault;
  logic load;
  logic step;
  logic cnt_zero;
  logic last_total;
  logic last_blk;

  assign fault = err_size | err_rpt_end | err_ovf;

  dma_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .step       (step),
    .total_in   (total_cnt),
    .blk_in     (blk_len),
    .cnt_zero   (cnt_zero),
    .last_total (last_total),
    .last_blk   (last_blk)
  );

  dma_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .req_n      (req_n),
    .mode       (mode),
    .yield_en   (yield_en),
    .fault      (fault),
    .bus_gnt    (bus_gnt),
    .cnt_zero   (cnt_zero),
    .last_total (last_total),
    .last_blk   (last_blk),
    .load       (load),
    .step       (step),
    .bus_req    (bus_req),
    .beat       (beat),
    .irq_done   (irq_done),
    .irq_err    (irq_err),
    .en_clr     (en_clr)
  );
endmodule

// File: tb/sim_dma_seq_top.sv
module sim_dma_seq_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic req_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic yield_en = 1'b0;
  logic [CNT_W-1:0] total_cnt = '0;
  logic [CNT_W-1:0] blk_len = '0;
  logic err_size = 1'b0, err_rpt_end = 1'b0, err_ovf = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req, beat, irq_done, irq_err, en_clr;

  int checks = 0, errors = 0, cycles = 0;
  int n_beats, n_rel, n_done, n_err, n_clr, n_reqcyc, run, max_run;
  bit mon_on = 1'b0, prev_req = 1'b0, gnt_block = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  dma_seq_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .req_n(req_n), .mode(mode),
    .yield_en(yield_en), .total_cnt(total_cnt), .blk_len(blk_len),
    .err_size(err_size), .err_rpt_end(err_rpt_end), .err_ovf(err_ovf),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .beat(beat), .irq_done(irq_done),
    .irq_err(irq_err), .en_clr(en_clr)
  );

  always @(posedge clk) begin
    #1;
    cycles++;
    if (mon_on) begin
      if (beat) begin
        n_beats++;
        run++;
        if (run > max_run) max_run = run;
      end
      if (!bus_req) run = 0;
      if (prev_req && !bus_req) n_rel++;
      if (irq_done) n_done++;
      if (irq_err) n_err++;
      if (en_clr) n_clr++;
      if (bus_req) n_reqcyc++;
    end
    prev_req = bus_req;
    bus_gnt <= bus_req && !gnt_block && (bus_gnt || ($urandom % 3 == 0));
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_beats = 0; n_rel = 0; n_done = 0; n_err = 0; n_clr = 0;
    n_reqcyc = 0; run = 0; max_run = 0;
  endtask

  function automatic int exp_rel(input logic [1:0] m, input bit y, input int n, input int b);
    if (m[1]) return n / b;
    if (m == 2'b01 && !y) return 1;
    return n;
  endfunction

  function automatic int exp_run(input logic [1:0] m, input bit y, input int n, input int b);
    if (m[1]) return b;
    if (m == 2'b01 && !y) return n;
    return 1;
  endfunction

  task automatic setup(input logic [1:0] m, input bit y, input int n, input int b);
    @(negedge clk);
    enable = 1'b0; req_n = 1'b1;
    mode = m; yield_en = y;
    total_cnt = CNT_W'(n); blk_len = CNT_W'(b);
    repeat (2) @(negedge clk);
    clear_mon();
    mon_on = 1'b1;
  endtask

  task automatic finish_run();
    enable = 1'b0; req_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic run_case(input logic [1:0] m, input bit y, input int n, input int b,
                          input bit drop_req);
    setup(m, y, n, b);
    enable = 1'b1; req_n = 1'b0;
    for (int i = 0; i < 3000 && n_clr == 0; i++) begin
      @(negedge clk);
      if (drop_req && n_beats >= 1) req_n = 1'b1;
    end
    finish_run();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(!bus_req && !beat && !irq_done && !irq_err && !en_clr, "R1 reset",
        {bus_req, beat, irq_done, irq_err, en_clr}, 0);

    // R1: enabled but no request, and request without enable
    setup(2'b00, 0, 4, 1);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    enable = 1'b0; req_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_reqcyc == 0, "R1 no request without enable and req_n", n_reqcyc, 0);
    finish_run();

    // R10: zero count never requests
    setup(2'b01, 0, 0, 1);
    enable = 1'b1; req_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_reqcyc == 0, "R10 zero count", n_reqcyc, 0);
    finish_run();

    // R2 cycle steal
    run_case(2'b00, 0, 5, 1, 0);
    chk(n_beats == 5, "R2 cs beats", n_beats, 5);
    chk(n_rel == 5, "R2 cs releases", n_rel, 5);
    chk(max_run == 1, "R2 cs run", max_run, 1);
    chk(n_done == 1 && n_clr == 1, "R7 cs done pulse", n_done, 1);

    // R3 burst
    run_case(2'b01, 0, 6, 1, 0);
    chk(n_beats == 6, "R3 burst beats", n_beats, 6);
    chk(n_rel == 1, "R3 burst releases", n_rel, 1);
    chk(max_run == 6, "R3 burst run", max_run, 6);

    // R4 burst keeps going after request withdrawn
    run_case(2'b01, 0, 6, 1, 1);
    chk(n_beats == 6, "R4 burst beats after req_n high", n_beats, 6);
    chk(n_rel == 1, "R4 burst releases", n_rel, 1);

    // R5 yield
    run_case(2'b01, 1, 4, 1, 0);
    chk(n_rel == 4, "R5 yield releases", n_rel, 4);
    chk(max_run == 1, "R5 yield run", max_run, 1);

    // R6 block, yield and mode[0] ignored
    run_case(2'b10, 0, 6, 3, 0);
    chk(n_rel == 2, "R6 block releases", n_rel, 2);
    chk(max_run == 3, "R6 block run", max_run, 3);
    run_case(2'b11, 1, 6, 3, 0);
    chk(n_rel == 2, "R6 block yield ignored", n_rel, 2);
    chk(n_beats == 6, "R7 block beats", n_beats, 6);

    // R8 disable after request, before grant
    setup(2'b00, 0, 5, 1);
    gnt_block = 1'b1;
    enable = 1'b1; req_n = 1'b0;
    for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    gnt_block = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_beats == 1, "R8 pending beat completes", n_beats, 1);
    chk(n_rel == 1, "R8 no further ownership", n_rel, 1);
    chk(n_done == 0 && n_clr == 0, "R8 no done", n_done + n_clr, 0);
    finish_run();

    // R9 each fault source aborts a burst
    for (int e = 0; e < 3; e++) begin
      setup(2'b01, 0, 10, 1);
      enable = 1'b1; req_n = 1'b0;
      for (int i = 0; i < 200 && n_beats < 3; i++) @(negedge clk);
      err_size = (e == 0); err_rpt_end = (e == 1); err_ovf = (e == 2);
      @(negedge clk);
      err_size = 1'b0; err_rpt_end = 1'b0; err_ovf = 1'b0;
      repeat (20) @(negedge clk);
      chk(n_beats == 3, "R9 beats stop at fault", n_beats, 3);
      chk(n_err == 1 && n_clr == 1, "R9 irq_err and en_clr", n_err, 1);
      chk(n_done == 0 && n_rel == 1, "R9 no done, bus dropped", n_done, 0);
      finish_run();
    end

    // random mix (R2, R3, R5, R6, R7, R11 via assertion)
    for (int t = 0; t < 24; t++) begin
      logic [1:0] m;
      bit y;
      int b, n;
      m = 2'($urandom % 4);
      y = 1'($urandom % 2);
      b = 1 + int'($urandom % 4);
      n = b * (1 + int'($urandom % 4));
      run_case(m, y, n, b, 0);
      chk(n_beats == n, "R7 random beats", n_beats, n);
      chk(n_rel == exp_rel(m, y, n, b), "R6 random releases", n_rel, exp_rel(m, y, n, b));
      chk(max_run == exp_run(m, y, n, b), "R3 random run", max_run, exp_run(m, y, n, b));
      chk(n_done == 1, "R7 random done", n_done, 1);
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule